// File: doc/BRIEF.md
# Bidirectional Serial/Parallel Conversion Register

This block is a small word register that turns a serial bit stream into a parallel word and a parallel word into a serial bit stream. Each bit of the stored word has a selector in front of it. A two-bit operation select picks what happens at the next rising clock edge:

- keep the stored word,
- take in a whole parallel word, or
- move every bit one place toward bit 0, with a fresh serial bit entering at the top.

For serial-to-parallel use, the caller shifts in one bit per cycle and reads the parallel output once the word is full. For parallel-to-serial use, the caller loads a word and then shifts it out of bit 0, one bit per cycle. An asynchronous clear empties the register at any time.

Top module: `srp_shift_reg`

## Requirements
- R1: While `clr` is 1, the stored word is 0 at once, without waiting for a clock edge. This holds for every `sel` value, and the word stays 0 across any rising edge while `clr` is 1.
- R2: With `sel` = 2'b00, a rising edge leaves the stored word unchanged.
- R3: With `sel` = 2'b11, a rising edge leaves the stored word unchanged, exactly as with 2'b00.
- R4: With `sel` = 2'b01, the rising edge stores `par_in`.
- R5: With `sel` = 2'b10, the rising edge moves bit i+1 into bit i for every i below the top bit and puts `ser_in` into the top bit (bit W-1). The old bit 0 is lost.
- R6: After W consecutive shifts, the first serial bit taken in sits in bit 0 and the last one sits in bit W-1.
- R7: `par_out` always shows the stored word, with no read strobe. `ser_out` always equals bit 0 of the stored word.
- R8: While `clr` is 0, the outputs change only at a rising clock edge. A change on `sel`, `ser_in` or `par_in` between edges has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| clr | input | 1 | Asynchronous clear, active high |
| sel | input | 2 | Operation: 00 hold, 01 load, 10 shift, 11 hold |
| ser_in | input | 1 | Serial bit entering the top bit on a shift |
| par_in | input | W | Parallel word taken on a load |
| par_out | output | W | Stored word |
| ser_out | output | 1 | Bit 0 of the stored word |

## Verification
The bench builds the register at its default width of four bits. At that width, a complete fill by shifting takes only four cycles, so the placement of first and last serial bits can be checked in full, and so can the dropping of bit 0. The vector table walks loads, both hold codes and shifts with changing serial input. Directed tests then apply the clear between edges and during a load request, and they change inputs between edges to show the outputs wait for the clock.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } srp_op_e;
endpackage

// File: rtl/srp_decode.sv
module srp_decode
  import srp_pkg::*;
(
  input  logic [1:0] sel,
  output srp_op_e    op,
  output logic       upd_en
);
  always_comb begin
    case (sel)
      2'b01:   op = OP_LOAD;
      2'b10:   op = OP_SHIFT;
      default: op = OP_HOLD;
    endcase
    upd_en = (op != OP_HOLD);
  end
endmodule

// File: rtl/srp_bit_sel.sv
module srp_bit_sel
  import srp_pkg::*;
(
  input  srp_op_e op,
  input  logic    cur_bit,
  input  logic    load_bit,
  input  logic    shift_bit,
  output logic    nxt_bit
);
  always_comb begin
    case (op)
      OP_LOAD:  nxt_bit = load_bit;
      OP_SHIFT: nxt_bit = shift_bit;
      default:  nxt_bit = cur_bit;
    endcase
  end
endmodule

// File: rtl/srp_store.sv
module srp_store #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/srp_shift_reg.sv
module srp_shift_reg
  import srp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [1:0]   sel,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] par_out,
  output logic         ser_out
);
  localparam int TOP = W - 1;

  srp_op_e      op;
  logic         upd_en;
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  srp_decode u_dec (
    .sel    (sel),
    .op     (op),
    .upd_en (upd_en)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic src;
    if (i == TOP) begin : g_top
      assign src = ser_in;
    end else begin : g_mid
      assign src = word_q[i+1];
    end
    srp_bit_sel u_sel (
      .op        (op),
      .cur_bit   (word_q[i]),
      .load_bit  (par_in[i]),
      .shift_bit (src),
      .nxt_bit   (word_d[i])
    );
  end

  srp_store #(.W(W)) u_store (
    .clk (clk),
    .clr (clr),
    .en  (upd_en),
    .d   (word_d),
    .q   (word_q)
  );

  assign par_out = word_q;
  assign ser_out = word_q[0];
endmodule

// File: rtl/srp_shift_reg_chk.sv
module srp_shift_reg_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr,
  input logic [1:0]   sel,
  input logic         ser_in,
  input logic [W-1:0] par_in,
  input logic [W-1:0] par_out,
  input logic         ser_out
);
  AST_CLEAR_ZERO: assert property (@(posedge clk) clr |-> (par_out == '0)); // R1
  AST_HOLD_00: assert property (@(posedge clk) disable iff (clr)
    (sel == 2'b00) |=> $stable(par_out)); // R2
  AST_HOLD_11: assert property (@(posedge clk) disable iff (clr)
    (sel == 2'b11) |=> $stable(par_out)); // R3
  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (clr)
    (sel == 2'b01) |=> (par_out == $past(par_in))); // R4
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (clr)
    (sel == 2'b10) |=> (par_out == {$past(ser_in), $past(par_out[W-1:1])})); // R5
endmodule

bind srp_shift_reg srp_shift_reg_chk #(.W(W)) u_chk (.*);

// File: tb/srp_shift_reg_test.sv
`timescale 1ns/1ps
module srp_shift_reg_test;
  localparam int W = 4;
  localparam int NV = 16;

  logic         clk;
  logic         clr;
  logic [1:0]   sel;
  logic         ser_in;
  logic [W-1:0] par_in;
  logic [W-1:0] par_out;
  logic         ser_out;

  int  n_chk;
  int  n_bad;
  bit  done;

  srp_shift_reg #(.W(W)) uut (
    .clk(clk), .clr(clr), .sel(sel), .ser_in(ser_in),
    .par_in(par_in), .par_out(par_out), .ser_out(ser_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {sel[1:0], ser_in, par_in[3:0], expected word after the edge[3:0]}
  localparam logic [10:0] VEC [NV] = '{
    {2'b01, 1'b0, 4'b1010, 4'b1010}, // R4 load
    {2'b00, 1'b1, 4'b0101, 4'b1010}, // R2 hold
    {2'b11, 1'b1, 4'b1111, 4'b1010}, // R3 hold
    {2'b10, 1'b1, 4'b0000, 4'b1101}, // R5 shift
    {2'b10, 1'b0, 4'b1111, 4'b0110}, // R5
    {2'b10, 1'b0, 4'b0000, 4'b0011}, // R5
    {2'b10, 1'b1, 4'b0000, 4'b1001}, // R5 bit 0 dropped
    {2'b01, 1'b1, 4'b0000, 4'b0000}, // R4 load zero
    {2'b10, 1'b1, 4'b0000, 4'b1000}, // R6 first bit
    {2'b10, 1'b0, 4'b1111, 4'b0100}, // R6
    {2'b10, 1'b0, 4'b0000, 4'b0010}, // R6
    {2'b10, 1'b0, 4'b0000, 4'b0001}, // R6 first bit now in bit 0
    {2'b11, 1'b1, 4'b1010, 4'b0001}, // R3
    {2'b01, 1'b0, 4'b1111, 4'b1111}, // R4
    {2'b10, 1'b0, 4'b0000, 4'b0111}, // R5
    {2'b00, 1'b1, 4'b0000, 4'b0111}  // R2
  };

  task automatic check(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (par_out !== exp || ser_out !== exp[0]) begin
      n_bad++;
      $display("FAIL %s: par_out=%b ser_out=%b expected par_out=%b ser_out=%b",
               req, par_out, ser_out, exp, exp[0]);
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    clr = 1'b1; sel = 2'b01; ser_in = 1'b1; par_in = 4'b1111;
    #1;
    check("R1 reset state", 4'b0000);
    @(posedge clk); #2;
    check("R1 clear overrides load", 4'b0000);
    @(negedge clk); clr = 1'b0; sel = 2'b00;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sel = VEC[i][10:9]; ser_in = VEC[i][8]; par_in = VEC[i][7:4];
      @(posedge clk); #2;
      check($sformatf("R7 vector %0d", i), VEC[i][3:0]);
    end
    check("R6 fill complete", 4'b0111);

    // R8: inputs changed between edges do not move outputs
    @(negedge clk); sel = 2'b01; par_in = 4'b1001; #1;
    check("R8 no change before edge", 4'b0111);
    @(posedge clk); #2;
    check("R4 load at edge", 4'b1001);
    @(negedge clk); sel = 2'b10; ser_in = 1'b0; #2;
    check("R8 shift waits for edge", 4'b1001);

    // R1: clear between edges acts at once
    @(negedge clk); sel = 2'b00; #1 clr = 1'b1; #1;
    check("R1 async clear", 4'b0000);
    @(negedge clk); clr = 1'b0; sel = 2'b10; ser_in = 1'b1;
    @(posedge clk); #2;
    check("R5 shift after clear", 4'b1000);
    @(negedge clk); sel = 2'b00;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule